// File: doc/BRIEF.md
# Successive-Approximation Converter Control Core

This block is the digital sequencer of an 8-bit successive-approximation converter that sits on a processor bus. The analog ladder and comparator live outside it. The block presents a trial code to the ladder and reads back a one-bit comparator verdict. From these it settles one result bit per slot, starting with the most significant bit. It copies the finished word into an output latch and signals completion with an active-low interrupt.

The bus side has three active-low strobes: chip select, write (start) and read. Each passes through a two-flop synchronizer into the conversion clock domain. A start latch keeps the successive-approximation state cleared for as long as select and write are both low, so a start strobe may be of any width. The conversion begins only when the strobe is released, and only on the next boundary of a free-running bit-slot phase counter.

A read with select low puts the latched word on the data bus and clears the interrupt. If a new start arrives during a conversion, that conversion is abandoned and the previous result is kept. Feeding the interrupt output back into the write strobe, with select held low, makes the block convert continuously.

Top module: `sar_ctrl`

## Requirements
- R1: After reset, intr_no is 1, data_oe_o is 0, data_o is 0x00, trial_o is 0x00, and the output latch holds 0x00: the first read returns 0x00.
- R2: While cs_ni and wr_ni are both low (after synchronization), trial_o is held at 0x00 and intr_no is held at 1.
- R3: The first clock edge that samples cs_ni or wr_ni high after a start is edge k. intr_no then goes low after an edge between k+68 and k+75, inclusive. The exact edge depends on the slot phase.
- R4: Bits are settled from the MSB downward, one per slot of 8 clocks. The first nonzero trial_o after a start is 0x80. trial_o changes only on slot boundaries, so every change comes a whole number of slots after the first.
- R5: At the end of each slot, cmp_i = 1 keeps the trial bit at 1 and cmp_i = 0 clears it. With a comparator that reports "input >= trial_o", the result equals the input code, so full scale 0xFF gives 1111 1111.
- R6: The output latch loads the finished word one clock after the last bit decision. intr_no falls one clock after that, which is exactly 66 clocks after the edge that first presents 0x80 on trial_o.
- R7: While cs_ni and rd_ni are both low, data_oe_o is 1 and data_o shows the latch, and intr_no returns to 1. Otherwise data_oe_o is 0 and data_o is 0x00.
- R8: A start issued during a conversion abandons it. The latch keeps the previous result, intr_no stays high until the new conversion finishes, and that conversion's result is then latched.
- R9: With cs_ni low and wr_ni driven by intr_no, no conversion happens until one external start pulse is given. After the pulse, conversions repeat without further stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| wr_ni | input | 1 | Start strobe, active low, asynchronous |
| rd_ni | input | 1 | Read strobe, active low, asynchronous |
| cmp_i | input | 1 | Comparator verdict: 1 when the input is at or above trial_o |
| trial_o | output | 8 | Trial code for the DAC ladder |
| data_o | output | 8 | Bus data; 0x00 when not enabled |
| data_oe_o | output | 1 | Bus output enable |
| intr_no | output | 1 | Conversion-complete interrupt, active low |

## Verification
The bench builds the block with its defaults: 8 result bits, 8-clock slots and 2-flop synchronizers. At that size, every one of the 256 input codes can be converted and read back, and each conversion's latency and trial-code timing can be measured against the allowed window. The 8-clock slot phase runs freely, so the sweep lands starts on many different phases and covers both ends of the launch delay. Abandoned conversions and the continuous mode, with the interrupt looped back into the write strobe, are run at the same configuration.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
  localparam int unsigned SAR_WIDTH  = 8;
  localparam int unsigned SLOT_CLKS  = 8;
  localparam int unsigned SYNC_DEPTH = 2;
  localparam int unsigned CTL_CH     = 3;

  typedef enum logic [1:0] {
    CH_CS = 2'd0,
    CH_WR = 2'd1,
    CH_RD = 2'd2
  } ctl_ch_e;
endpackage

// File: rtl/sar_sync.sv
`timescale 1ns/1ps
module sar_sync #(
  parameter int unsigned N     = 3,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic [DEPTH-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '1;  // strobes idle high
      else         sh_q <= {sh_q[DEPTH-2:0], d_i[g]};
    end
    assign q_o[g] = sh_q[DEPTH-1];
  end
endmodule

// File: rtl/sar_start.sv
`timescale 1ns/1ps
module sar_start #(
  parameter int unsigned SLOT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_s_i,
  input  logic wr_s_i,
  output logic hold_o,
  output logic launch_o,
  output logic slot_end_o
);
  localparam int unsigned PW = (SLOT > 1) ? $clog2(SLOT) : 1;
  localparam logic [PW-1:0] LAST = PW'(SLOT - 1);

  logic [PW-1:0] phase_q;
  logic          pending_q;

  assign hold_o     = ~cs_s_i & ~wr_s_i;
  assign slot_end_o = (phase_q == LAST);
  assign launch_o   = pending_q & ~hold_o & slot_end_o;

  // free-running slot phase; launch aligns to its wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= slot_end_o ? '0 : phase_q + PW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pending_q <= 1'b0;
    else if (hold_o)   pending_q <= 1'b1;
    else if (launch_o) pending_q <= 1'b0;
  end
endmodule

// File: rtl/sar_engine.sv
`timescale 1ns/1ps
module sar_engine #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             launch_i,
  input  logic             slot_end_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] trial_o,
  output logic [WIDTH-1:0] result_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] marker_q;  // one-hot bit under test
  logic [WIDTH-1:0] sar_q;
  logic             busy_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      marker_q <= '0;
      sar_q    <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else if (clear_i) begin
      marker_q <= '0;
      sar_q    <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (launch_i) begin
        busy_q   <= 1'b1;
        marker_q <= MSB_ONLY;
        sar_q    <= '0;
      end else if (busy_q && slot_end_i) begin
        if (cmp_i) sar_q <= sar_q | marker_q;
        marker_q <= marker_q >> 1;
        if (marker_q[0]) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign trial_o  = sar_q | marker_q;
  assign result_o = sar_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;
endmodule

// File: rtl/sar_ctrl.sv
`timescale 1ns/1ps
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int unsigned WIDTH = SAR_WIDTH,
  parameter int unsigned SLOT  = SLOT_CLKS,
  parameter int unsigned SYNC  = SYNC_DEPTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             wr_ni,
  input  logic             rd_ni,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] trial_o,
  output logic [WIDTH-1:0] data_o,
  output logic             data_oe_o,
  output logic             intr_no
);
  logic [CTL_CH-1:0] ctl_raw, ctl_s;
  logic              cs_s, wr_s, rd_s, rd_act;
  logic              hold, launch, slot_end, busy, done;
  logic [WIDTH-1:0]  result, latch_q;
  logic              upd_q, flag_q;

  assign ctl_raw[CH_CS] = cs_ni;
  assign ctl_raw[CH_WR] = wr_ni;
  assign ctl_raw[CH_RD] = rd_ni;

  sar_sync #(.N(CTL_CH), .DEPTH(SYNC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctl_raw),
    .q_o   (ctl_s)
  );

  assign cs_s   = ctl_s[CH_CS];
  assign wr_s   = ctl_s[CH_WR];
  assign rd_s   = ctl_s[CH_RD];
  assign rd_act = ~cs_s & ~rd_s;

  sar_start #(.SLOT(SLOT)) u_start (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_s_i    (cs_s),
    .wr_s_i    (wr_s),
    .hold_o    (hold),
    .launch_o  (launch),
    .slot_end_o(slot_end)
  );

  sar_engine #(.WIDTH(WIDTH)) u_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (hold),
    .launch_i  (launch),
    .slot_end_i(slot_end),
    .cmp_i     (cmp_i),
    .trial_o   (trial_o),
    .result_o  (result),
    .busy_o    (busy),
    .done_o    (done)
  );

  // latch on completion; flag one clock later; hold and read clear it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      upd_q   <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      upd_q <= done & ~hold;
      if (done && !hold) latch_q <= result;
      if (hold || rd_act) flag_q <= 1'b0;
      else if (upd_q)     flag_q <= 1'b1;
    end
  end

  assign data_oe_o = rd_act;
  assign data_o    = rd_act ? latch_q : '0;
  assign intr_no   = ~flag_q;
endmodule

// File: rtl/sar_ctrl_chk.sv
`timescale 1ns/1ps
module sar_ctrl_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hold_i,
  input logic             rd_act_i,
  input logic             busy_i,
  input logic             slot_end_i,
  input logic             done_i,
  input logic             intr_ni,
  input logic [WIDTH-1:0] trial_i,
  input logic [WIDTH-1:0] latch_i
);
  a_r2_hold_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (intr_ni && trial_i == '0));

  a_r4_trial_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !hold_i && !slot_end_i) |=> $stable(trial_i));

  a_r6_intr_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(intr_ni) |-> $past(done_i, 2));

  a_r6_latch_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !hold_i) |=> (latch_i == $past(trial_i)));

  a_r7_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_act_i |=> intr_ni);

  a_r8_abort_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(latch_i));
endmodule

bind sar_ctrl sar_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .hold_i    (hold),
  .rd_act_i  (rd_act),
  .busy_i    (busy),
  .slot_end_i(slot_end),
  .done_i    (done),
  .intr_ni   (intr_no),
  .trial_i   (trial_o),
  .latch_i   (latch_q)
);

// File: tb/sar_ctrl_tb.sv
`timescale 1ns/1ps
module sar_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_drv = 1'b1, wr_drv = 1'b1, rd_drv = 1'b1;
  logic       free_mode = 1'b0;
  logic       wr_dut;
  logic [7:0] vin = 8'h00;
  logic       cmp;
  logic [7:0] trial_o, data_o;
  logic       data_oe_o, intr_no;
  int         n_chk = 0, n_fail = 0;
  bit         finished = 0;

  always #2 clk_i = ~clk_i;

  assign wr_dut = free_mode ? (intr_no & wr_drv) : wr_drv;
  assign cmp    = (vin >= trial_o);

  sar_ctrl u_dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_ni    (cs_drv),
    .wr_ni    (wr_dut),
    .rd_ni    (rd_drv),
    .cmp_i    (cmp),
    .trial_o  (trial_o),
    .data_o   (data_o),
    .data_oe_o(data_oe_o),
    .intr_no  (intr_no)
  );

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start_pulse();
    cs_drv = 1'b0;
    wr_drv = 1'b0;
    repeat (4) tick();
    chk(trial_o == 8'h00 && intr_no == 1'b1, "R2 hold clears trial and intr",
        {trial_o, 7'd0, intr_no}, 1);
    cs_drv = 1'b1;
    wr_drv = 1'b1;
  endtask

  task automatic run_conv(output int lat, output int first_at, output bit spacing_ok);
    logic [7:0] prev;
    first_at   = -1;
    spacing_ok = 1'b1;
    lat        = -1;
    start_pulse();
    prev = trial_o;
    for (int i = 1; i <= 200; i++) begin
      tick();
      if (trial_o !== prev) begin
        if (first_at < 0) begin
          first_at = i;
          if (trial_o !== 8'h80) spacing_ok = 1'b0;
        end else if (((i - first_at) % 8) != 0) spacing_ok = 1'b0;
        prev = trial_o;
      end
      if (intr_no == 1'b0) begin
        lat = i;
        break;
      end
    end
  endtask

  task automatic do_read(output logic [7:0] d, output logic oe, output logic intr_after);
    cs_drv = 1'b0;
    rd_drv = 1'b0;
    repeat (3) tick();
    d          = data_o;
    oe         = data_oe_o;
    intr_after = intr_no;
    cs_drv = 1'b1;
    rd_drv = 1'b1;
    repeat (3) tick();
    chk(data_o == 8'h00 && data_oe_o == 1'b0, "R7 bus off after read",
        {data_o, data_oe_o}, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    finish_run();
  end

  initial begin
    int lat, first_at, falls;
    bit sp;
    logic [7:0] d;
    logic oe, ia, prev_intr;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    tick();
    // R1 reset state
    chk(intr_no == 1'b1, "R1 intr idle", intr_no, 1);
    chk(data_oe_o == 1'b0 && data_o == 8'h00, "R1 bus disabled", {data_o, data_oe_o}, 0);
    chk(trial_o == 8'h00, "R1 trial zero", trial_o, 0);
    do_read(d, oe, ia);
    chk(d == 8'h00 && oe == 1'b1, "R1 latch zero on first read", d, 0);

    // R3 R4 R5 R6 R7: exhaustive code sweep
    for (int v = 0; v < 256; v++) begin
      vin = 8'(v);
      run_conv(lat, first_at, sp);
      chk(lat >= 69 && lat <= 76, "R3 launch latency window", lat - 1, 68);
      chk(sp, "R4 MSB first and slot spacing", first_at, 0);
      chk(lat - first_at == 66, "R6 intr 66 clocks after first trial", lat - first_at, 66);
      do_read(d, oe, ia);
      chk(d == 8'(v) && oe == 1'b1, "R5 result equals input", d, v);
      chk(ia == 1'b1, "R7 read clears intr", ia, 1);
    end

    // R8 abort keeps previous result
    vin = 8'h5A;
    run_conv(lat, first_at, sp);
    do_read(d, oe, ia);
    chk(d == 8'h5A, "R8 baseline result", d, 8'h5A);
    vin = 8'h33;
    start_pulse();
    repeat (30) tick();
    start_pulse();
    repeat (5) tick();
    chk(intr_no == 1'b1, "R8 no intr from abandoned run", intr_no, 1);
    do_read(d, oe, ia);
    chk(d == 8'h5A, "R8 latch keeps previous result", d, 8'h5A);
    lat = -1;
    for (int i = 0; i < 200; i++) begin
      tick();
      if (intr_no == 1'b0) begin
        lat = i;
        break;
      end
    end
    chk(lat >= 0, "R8 restarted conversion completes", lat, 0);
    do_read(d, oe, ia);
    chk(d == 8'h33, "R8 new result latched", d, 8'h33);

    // R9 free-running loop
    vin       = 8'hC3;
    cs_drv    = 1'b0;
    free_mode = 1'b1;
    falls     = 0;
    for (int i = 0; i < 200; i++) begin
      tick();
      if (intr_no == 1'b0) falls++;
    end
    chk(falls == 0, "R9 no start without pulse", falls, 0);
    wr_drv = 1'b0;
    repeat (4) tick();
    wr_drv = 1'b1;
    prev_intr = intr_no;
    falls = 0;
    for (int i = 0; i < 500; i++) begin
      tick();
      if (prev_intr == 1'b1 && intr_no == 1'b0) falls++;
      prev_intr = intr_no;
    end
    chk(falls >= 5, "R9 repeated conversions", falls, 5);
    free_mode = 1'b0;
    cs_drv    = 1'b1;
    for (int i = 0; i < 200; i++) begin
      if (intr_no == 1'b0) break;
      tick();
    end
    do_read(d, oe, ia);
    chk(d == 8'hC3, "R9 free-run result", d, 8'hC3);

    finish_run();
  end
endmodule